// File: doc/BRIEF.md
# Buffered Register Update Synchronizer

This block keeps two copies of a small control register set: a shadow copy that a parallel write port fills at any time, and an active copy that drives the rest of the chip. The block divides the fast system clock by four to make a slower synchronization clock and drives that clock out, so external logic can time its update strobe from it. The update strobe, a 2-bit profile select and an on-off keying input are all registered on the rising edge of that divided clock.

A low-to-high change of the registered update strobe makes one load pulse. The pulse copies the whole shadow set into the active set in a single step. New tuning, phase and amplitude values therefore land together, at a fixed number of fast clock cycles after the divided clock edge. A two-bit mode field in the active control register decides what goes out as the datapath amplitude scale factor: either the active amplitude register, or full scale.

All logic runs on the system clock. The divided clock is a register output, and sampling happens under a clock enable, so there is no second clock tree inside the block.

Top module: `regbank_update_sync`

## Requirements
- R1: `sync_clk` is the system clock divided by exactly 4. After reset it is low for the first two system clock edges and high for the next two, and the pattern repeats.
- R2: `prof_q` and `osk_q` take the values that `prof_in` and `osk_in` had at the system clock edge where `sync_clk` rises. They hold those values until the next such edge.
- R3: Loads happen only at `sync_clk` rising edges. When a sampling edge first sees `upd_in` high, the active set takes the whole shadow set at the next `sync_clk` rising edge, one divided cycle later.
- R4: Holding `upd_in` high for any number of cycles gives exactly one load. Shadow writes made while it stays high do not reach the active set.
- R5: A write with `wr_en` high stores `wr_data` into shadow word `wr_addr`. The active set does not change until a load. Address map: 0 control, 1 frequency tuning word, 2 phase offset, 3 amplitude (bits 13:0).
- R6: A write at the same edge as a load goes into the shadow set only. The load copies the shadow value from before that write, and the new value reaches the active set at the following load.
- R7: When active control bits 25:24 equal binary 10, `scale_out` equals active amplitude bits 13:0.
- R8: For every other value of active control bits 25:24, `scale_out` is all ones (14'h3FFF).
- R9: While `rst_n` is low, the divider phase, the strobe history, the sampled inputs and both register sets are zero, and `sync_clk` is low.
- R10: A strobe that is seen low at just one sampling edge between two highs re-arms the detector, and the second high gives a second load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Shadow write strobe, one system cycle per write |
| wr_addr | input | 2 | Shadow word index |
| wr_data | input | 32 | Shadow write data |
| upd_in | input | 1 | External update strobe |
| prof_in | input | 2 | Profile select input |
| osk_in | input | 1 | On-off keying input |
| sync_clk | output | 1 | System clock divided by four |
| prof_q | output | 2 | Profile select registered on the divided clock |
| osk_q | output | 1 | Keying input registered on the divided clock |
| active_bus | output | 128 | Active register set, word i at bits 32*i+31 : 32*i |
| scale_out | output | 14 | Datapath amplitude scale factor |

## Verification
The assertions assume that `upd_in`, `prof_in` and `osk_in` are already synchronous to the system clock and meet setup at every edge. They also assume that `wr_addr` names an implemented word whenever `wr_en` is high. The bench drives every input only on falling system clock edges, keeps addresses in the range 0 to 3, and never lowers the strobe for fewer than four system cycles. Four system cycles always contain one sampling edge, so the R10 re-arm case always sees a low sample.

// File: rtl/upd_sync_pkg.sv
package upd_sync_pkg;

   localparam int unsigned IDX_CTRL  = 0;
   localparam int unsigned IDX_FREQ  = 1;
   localparam int unsigned IDX_PHASE = 2;
   localparam int unsigned IDX_AMP   = 3;
   localparam int unsigned MIN_WORDS = 4;

   typedef enum logic [1:0] {
      AMODE_OFF  = 2'b00,
      AMODE_AUTO = 2'b01,
      AMODE_EXT  = 2'b10,
      AMODE_BOTH = 2'b11
   } amp_mode_e;

endpackage

// File: rtl/sync_div.sv
module sync_div #(
   parameter int unsigned DIV = 4,
   localparam int unsigned CW = $clog2(DIV)
) (
   input  logic sys_clk,
   input  logic rst_n,
   output logic sync_clk,
   output logic samp_en
);

   generate
      if (DIV < 2 || (DIV & (DIV - 1)) != 0) begin : g_bad_div
         $error("sync_div: DIV must be a power of two of at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   assign sync_clk = cnt[CW-1];
   // at this edge the counter crosses into its upper half, so the divided clock rises
   assign samp_en  = (cnt == CW'(DIV / 2 - 1));

endmodule

// File: rtl/strobe_edge.sv
module strobe_edge #(
   parameter int unsigned PROF_W = 2
) (
   input  logic              sys_clk,
   input  logic              rst_n,
   input  logic              samp_en,
   input  logic              upd_in,
   input  logic [PROF_W-1:0] prof_in,
   input  logic              osk_in,
   output logic              upd_smp,
   output logic              upd_load,
   output logic [PROF_W-1:0] prof_q,
   output logic              osk_q
);

   logic upd_hist;

   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_smp  <= 1'b0;
         upd_hist <= 1'b0;
         prof_q   <= '0;
         osk_q    <= 1'b0;
      end else if (samp_en) begin
         upd_smp  <= upd_in;
         upd_hist <= upd_smp;
         prof_q   <= prof_in;
         osk_q    <= osk_in;
      end
   end

   assign upd_load = samp_en & upd_smp & ~upd_hist;

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned DATA_W   = 32,
   localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic                         sys_clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         upd_load,
   output logic [NUM_REGS*DATA_W-1:0]   shadow_bus,
   output logic [NUM_REGS*DATA_W-1:0]   active_bus
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      logic [DATA_W-1:0] shd_q;
      logic [DATA_W-1:0] act_q;

      always_ff @(posedge sys_clk or negedge rst_n) begin
         if (!rst_n) begin
            shd_q <= '0;
            act_q <= '0;
         end else begin
            if (wr_en && wr_addr == ADDR_W'(i)) shd_q <= wr_data;
            if (upd_load)                       act_q <= shd_q;
         end
      end

      assign shadow_bus[i*DATA_W +: DATA_W] = shd_q;
      assign active_bus[i*DATA_W +: DATA_W] = act_q;
   end

endmodule

// File: rtl/amp_select.sv
module amp_select #(
   parameter int unsigned ASF_W = 14
) (
   input  logic [1:0]       mode_bits,
   input  logic [ASF_W-1:0] amp_word,
   output logic [ASF_W-1:0] scale_out
);

   import upd_sync_pkg::*;

   amp_mode_e mode;

   always_comb begin
      mode      = amp_mode_e'(mode_bits);
      scale_out = (mode == AMODE_EXT) ? amp_word : {ASF_W{1'b1}};
   end

endmodule

// File: rtl/regbank_update_sync.sv
module regbank_update_sync #(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ASF_W    = 14,
   parameter int unsigned PROF_W   = 2,
   parameter int unsigned DIV      = 4,
   parameter int unsigned MODE_LSB = 24,
   localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
   localparam int unsigned BUS_W   = NUM_REGS * DATA_W
) (
   input  logic              sys_clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              upd_in,
   input  logic [PROF_W-1:0] prof_in,
   input  logic              osk_in,
   output logic              sync_clk,
   output logic [PROF_W-1:0] prof_q,
   output logic              osk_q,
   output logic [BUS_W-1:0]  active_bus,
   output logic [ASF_W-1:0]  scale_out
);

   import upd_sync_pkg::*;

   generate
      if (NUM_REGS < MIN_WORDS) begin : g_bad_words
         $error("regbank_update_sync: NUM_REGS below the four named words");
      end
      if (MODE_LSB + 2 > DATA_W || ASF_W > DATA_W) begin : g_bad_fields
         $error("regbank_update_sync: mode or amplitude field exceeds DATA_W");
      end
   endgenerate

   logic             samp_en;
   logic             upd_smp;
   logic             upd_load;
   logic [BUS_W-1:0] shadow_bus;

   sync_div #(.DIV(DIV)) u_div (
      .sys_clk  (sys_clk),
      .rst_n    (rst_n),
      .sync_clk (sync_clk),
      .samp_en  (samp_en)
   );

   strobe_edge #(.PROF_W(PROF_W)) u_edge (
      .sys_clk  (sys_clk),
      .rst_n    (rst_n),
      .samp_en  (samp_en),
      .upd_in   (upd_in),
      .prof_in  (prof_in),
      .osk_in   (osk_in),
      .upd_smp  (upd_smp),
      .upd_load (upd_load),
      .prof_q   (prof_q),
      .osk_q    (osk_q)
   );

   shadow_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
      .sys_clk    (sys_clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .upd_load   (upd_load),
      .shadow_bus (shadow_bus),
      .active_bus (active_bus)
   );

   amp_select #(.ASF_W(ASF_W)) u_amp (
      .mode_bits (active_bus[IDX_CTRL*DATA_W + MODE_LSB +: 2]),
      .amp_word  (active_bus[IDX_AMP*DATA_W +: ASF_W]),
      .scale_out (scale_out)
   );

endmodule

// File: rtl/regbank_update_sync_chk.sv
module regbank_update_sync_chk #(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ASF_W    = 14,
   parameter int unsigned PROF_W   = 2,
   parameter int unsigned MODE_LSB = 24,
   localparam int unsigned BUS_W   = NUM_REGS * DATA_W
) (
   input logic              sys_clk,
   input logic              rst_n,
   input logic              samp_en,
   input logic              sync_clk,
   input logic              upd_smp,
   input logic              upd_load,
   input logic [PROF_W-1:0] prof_in,
   input logic [PROF_W-1:0] prof_q,
   input logic [BUS_W-1:0]  shadow_bus,
   input logic [BUS_W-1:0]  active_bus,
   input logic [ASF_W-1:0]  scale_out
);

   import upd_sync_pkg::*;

   logic             seen_low;
   logic [1:0]       mode_bits;
   logic [ASF_W-1:0] amp_bits;

   assign mode_bits = active_bus[IDX_CTRL*DATA_W + MODE_LSB +: 2];
   assign amp_bits  = active_bus[IDX_AMP*DATA_W +: ASF_W];

   // tracks whether a low strobe sample has occurred since the last load
   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n)                     seen_low <= 1'b0;
      else if (upd_load)              seen_low <= 1'b0;
      else if (samp_en && !upd_smp)   seen_low <= 1'b1;
   end

   AST_DIV_RISE: assert property (@(posedge sys_clk) disable iff (!rst_n)
      $rose(sync_clk) |-> $past(samp_en)); // R1

   AST_PROF_SAMPLED: assert property (@(posedge sys_clk) disable iff (!rst_n)
      samp_en |=> (prof_q == $past(prof_in))); // R2

   AST_LOAD_ON_EDGE: assert property (@(posedge sys_clk) disable iff (!rst_n)
      upd_load |-> samp_en); // R3

   AST_LOAD_COPIES: assert property (@(posedge sys_clk) disable iff (!rst_n)
      upd_load |=> (active_bus == $past(shadow_bus))); // R3

   AST_ONE_LOAD_PER_HIGH: assert property (@(posedge sys_clk) disable iff (!rst_n)
      upd_load |-> seen_low); // R4

   AST_ACTIVE_HELD: assert property (@(posedge sys_clk) disable iff (!rst_n)
      !upd_load |=> $stable(active_bus)); // R5

   AST_EXT_SCALE: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (mode_bits == AMODE_EXT) |-> (scale_out == amp_bits)); // R7

   AST_FULL_SCALE: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (mode_bits != AMODE_EXT) |-> (&scale_out)); // R8

endmodule

bind regbank_update_sync regbank_update_sync_chk #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .ASF_W    (ASF_W),
   .PROF_W   (PROF_W),
   .MODE_LSB (MODE_LSB)
) u_chk (
   .sys_clk    (sys_clk),
   .rst_n      (rst_n),
   .samp_en    (samp_en),
   .sync_clk   (sync_clk),
   .upd_smp    (upd_smp),
   .upd_load   (upd_load),
   .prof_in    (prof_in),
   .prof_q     (prof_q),
   .shadow_bus (shadow_bus),
   .active_bus (active_bus),
   .scale_out  (scale_out)
);

// File: tb/sim_regbank_update_sync.sv
`timescale 1ns/1ps
module sim_regbank_update_sync;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic         upd_in = 1'b0;
   logic [1:0]   prof_in = '0;
   logic         osk_in = 1'b0;
   logic         sync_clk;
   logic [1:0]   prof_q;
   logic         osk_q;
   logic [127:0] active_bus;
   logic [13:0]  scale_out;

   int  nchk = 0;
   int  nfail = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   regbank_update_sync u0 (
      .sys_clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .upd_in (upd_in), .prof_in (prof_in), .osk_in (osk_in),
      .sync_clk (sync_clk), .prof_q (prof_q), .osk_q (osk_q),
      .active_bus (active_bus), .scale_out (scale_out)
   );

   // behavioural reference: count edges since reset, act on every fourth
   int          n = 0;
   logic [31:0] m_shd [4];
   logic [31:0] m_act [4];
   bit          m_cur = 0, m_prev = 0, m_osk = 0;
   logic [1:0]  m_prof = '0;

   initial for (int i = 0; i < 4; i++) begin m_shd[i] = '0; m_act[i] = '0; end

   always @(posedge clk) begin
      if (!rst_n) begin
         n = 0; m_cur = 0; m_prev = 0; m_osk = 0; m_prof = '0;
         for (int i = 0; i < 4; i++) begin m_shd[i] = '0; m_act[i] = '0; end
      end else begin
         n = n + 1;
         if (n % 4 == 2) begin
            if (m_cur && !m_prev) for (int i = 0; i < 4; i++) m_act[i] = m_shd[i];
            m_prev = m_cur;
            m_cur  = upd_in;
            m_prof = prof_in;
            m_osk  = osk_in;
         end
         if (wr_en) m_shd[wr_addr] = wr_data;
      end
   end

   function automatic logic [13:0] exp_scale();
      return (m_act[0][25:24] == 2'b10) ? m_act[3][13:0] : 14'h3FFF;
   endfunction

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         check("R1 sync_clk", 128'(sync_clk), 128'((n % 4) >= 2));
         check("R2 prof_q", 128'(prof_q), 128'(m_prof));
         check("R2 osk_q", 128'(osk_q), 128'(m_osk));
         check("R3 R5 active_bus", active_bus,
               {m_act[3], m_act[2], m_act[1], m_act[0]});
         check("R7 R8 scale_out", 128'(scale_out), 128'(exp_scale()));
      end
   end

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_upd();
      upd_in = 1'b0; idle(8);
      upd_in = 1'b1; idle(12);
      upd_in = 1'b0; idle(8);
   endtask

   function automatic logic [31:0] word(input int i);
      return active_bus[i*32 +: 32];
   endfunction

   initial begin
      int rises;
      bit prev_s;
      idle(3);
      // R9: everything zero while reset is held
      check("R9 active in reset", active_bus, '0);
      check("R9 sync_clk in reset", 128'(sync_clk), 128'(0));
      check("R9 prof_q in reset", 128'(prof_q), 128'(0));
      @(negedge clk); rst_n = 1'b1;

      // R5: writes stay in shadow
      wr(2'd0, 32'h0200_0000);
      wr(2'd1, 32'h1234_5678);
      wr(2'd2, 32'h0000_4321);
      wr(2'd3, 32'h0000_1ABC);
      idle(10);
      check("R5 no load without update", active_bus, '0);

      // R3: latency in divided clock rises from strobe high to new values
      upd_in = 1'b1;
      rises = 0; prev_s = sync_clk;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (sync_clk && !prev_s) rises++;
         prev_s = sync_clk;
         if (active_bus != '0) break;
      end
      check("R3 load latency in sync rises", 128'(rises), 128'(2));
      check("R3 tuning word loaded", 128'(word(1)), 128'(32'h1234_5678));
      check("R7 scale follows amplitude", 128'(scale_out), 128'(14'h1ABC));

      // R4: held high, later writes do not load
      wr(2'd1, 32'hCAFE_0001);
      idle(40);
      check("R4 no reload while held", 128'(word(1)), 128'(32'h1234_5678));

      // R10: one low sample re-arms
      upd_in = 1'b0; idle(4);
      upd_in = 1'b1; idle(12);
      check("R10 second load after short low", 128'(word(1)), 128'(32'hCAFE_0001));

      // R6: write landing on the load edge
      upd_in = 1'b0; idle(12);
      wr(2'd3, 32'h0000_0F0F);
      upd_in = 1'b1;
      while (n % 4 != 1) @(negedge clk);
      @(negedge clk);
      while (n % 4 != 1) @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'h0000_0555;
      @(negedge clk);
      wr_en = 1'b0;
      check("R6 load takes pre-write shadow", 128'(word(3)), 128'(32'h0000_0F0F));
      pulse_upd();
      check("R6 collided write at next load", 128'(word(3)), 128'(32'h0000_0555));
      check("R7 scale after reload", 128'(scale_out), 128'(14'h0555));

      // R8: other mode values give full scale
      wr(2'd0, 32'h0300_0000); pulse_upd();
      check("R8 mode 11 full scale", 128'(scale_out), 128'(14'h3FFF));
      wr(2'd0, 32'h0100_0000); pulse_upd();
      check("R8 mode 01 full scale", 128'(scale_out), 128'(14'h3FFF));
      wr(2'd0, 32'h0000_0000); pulse_upd();
      check("R8 mode 00 full scale", 128'(scale_out), 128'(14'h3FFF));

      // R2: varied profile and keying patterns, compared every cycle
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         prof_in = 2'($urandom);
         osk_in  = 1'($urandom);
         if (k % 37 == 0) upd_in = ~upd_in;
         if (k % 5 == 0) begin
            wr_en = 1'b1; wr_addr = 2'($urandom); wr_data = $urandom;
         end else wr_en = 1'b0;
      end
      wr_en = 1'b0; idle(8);

      // R9: reset in mid-run clears state again
      rst_n = 1'b0; idle(2);
      check("R9 active after reset", active_bus, '0);
      check("R9 scale after reset", 128'(scale_out), 128'(14'h3FFF));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         nchk++; nfail++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

endmodule